// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM with 8-bit words, organised as 1M words at the default address width. The host presents one request at a time: an address, a read/write flag and, for writes, a data byte, held until the controller shows it is ready. The controller then plays the strobe sequence the memory needs. It drives two chip selects of opposite polarity, an active-low output enable and an active-low write enable. It also drives a data bus that the surrounding pad logic makes tri-state through a drive-enable.

Every analog timing limit of the memory is written in nanoseconds inside the block. Each limit is turned into a whole number of clock cycles at elaboration, using the clock-period parameter and the selected speed grade (55 ns or 70 ns). Reads hold the output enable and address for long enough to cover access time, capture the byte on their last cycle and return it with a one-cycle valid pulse. Writes keep the output enable high, turn the data driver on only after the write strobe has fallen, and end the write by raising the write strobe and deselecting together. After every read the controller leaves a turnaround gap before the bus can be driven again.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, and in every idle cycle, ready is 1, mem_cs1_n is 1, mem_cs2 is 0, mem_oe_n is 1, mem_we_n is 1, mem_dq_oe is 0 and rd_valid is 0.
- R2: A request is taken only on a clock edge where req and ready are both 1. While ready is 0, req, req_wr, req_addr and req_wdata have no effect, and mem_addr holds its value.
- R3: A read selects the memory (mem_cs1_n 0, mem_cs2 1) with mem_we_n 1 and mem_oe_n 0, keeps mem_addr stable for the whole window, and samples mem_dq_in at the edge that closes its last cycle. The read is therefore at least the address access time and output-enable access time after the address and the enable were applied.
- R4: rd_valid is 1 for exactly one cycle, the cycle right after the last cycle with mem_oe_n low. During that cycle rdata holds the captured byte, and it keeps that byte until the next capture.
- R5: During a write mem_oe_n stays 1. The write strobe stays low for at least the write pulse width, mem_addr is stable for at least the address-to-end time before the write ends, and two write starts are at least one write cycle time apart.
- R6: mem_dq_oe rises only after mem_we_n has been low for a full cycle. The driven byte is on the bus for at least the data setup time before the write ends, and mem_dq_oe stays 1 in the cycle after mem_we_n rises.
- R7: After a read, the memory is deselected with mem_oe_n high for at least the bus release time, rounded up to cycles, before mem_dq_oe may rise. mem_dq_oe is never 1 while mem_oe_n is low or in the cycle after it was low.
- R8: Each nanosecond limit becomes ceil(ns / CLK_PERIOD_NS) cycles, never less than 1. A read keeps mem_oe_n low for max(read cycle, address access) cycles. A write keeps mem_we_n low for 1 + max(setup, pulse − 1, address-to-end − 1, write cycle − 2) cycles. With SPEED_GRADE 55 the limits are 55/55/55/45/40/25/20 ns (read cycle, access, write cycle, address-to-end, pulse, setup, release); with 70 they are 70/70/70/60/50/30/25 ns.
- R9: A byte written to an address is returned by any later read of that address until it is overwritten, and writes to other addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request; taken when ready is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Byte to store on a write |
| ready | output | 1 | Controller idle and able to take a request |
| rdata | output | DATA_W | Byte captured by the last read |
| rd_valid | output | 1 | One-cycle pulse marking fresh rdata |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data-bus drive enable |
| mem_dq_in | input | DATA_W | Byte seen on the data bus |

## Verification
The read-data return and the start of a write can land in the same cycle. rd_valid fires in the first turnaround cycle, while a host that already holds a write request is waiting for ready. The bench provokes this by raising a write request as soon as a read is taken and holding it through the whole read. It then judges three things: the returned byte matches, the pending write is not taken before ready returns, and the bus model records at least the release time between the end of the read enable and the rise of the drive enable. A nanosecond-timed memory model in the bench returns a junk byte whenever a sample comes too early, and flags any write whose strobes break the pulse, setup or address limits.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_TURN,
      ST_WR_OPEN,
      ST_WR_DATA,
      ST_WR_CLOSE
   } seq_state_e;

   typedef enum int {
      TP_RC,
      TP_AA,
      TP_WC,
      TP_AW,
      TP_PWE,
      TP_SD,
      TP_HZ
   } tparam_e;

   typedef struct packed {
      logic ready;
      logic cs;
      logic oe;
      logic we;
      logic drv;
   } strobe_t;

   function automatic int grade_ns(input int grade, input tparam_e p);
      int v;
      v = 0;
      if (grade == 70) begin
         case (p)
            TP_RC:   v = 70;
            TP_AA:   v = 70;
            TP_WC:   v = 70;
            TP_AW:   v = 60;
            TP_PWE:  v = 50;
            TP_SD:   v = 30;
            TP_HZ:   v = 25;
            default: v = 70;
         endcase
      end else begin
         case (p)
            TP_RC:   v = 55;
            TP_AA:   v = 55;
            TP_WC:   v = 55;
            TP_AW:   v = 45;
            TP_PWE:  v = 40;
            TP_SD:   v = 25;
            TP_HZ:   v = 20;
            default: v = 55;
         endcase
      end
      return v;
   endfunction

   function automatic int ns_to_cyc(input int ns, input int period);
      int c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic strobe_t decode_strobes(input seq_state_e s);
      strobe_t t;
      t.ready = (s == ST_IDLE);
      t.cs    = (s == ST_RD) || (s == ST_WR_OPEN) || (s == ST_WR_DATA);
      t.oe    = (s == ST_RD);
      t.we    = (s == ST_WR_OPEN) || (s == ST_WR_DATA);
      t.drv   = (s == ST_WR_DATA) || (s == ST_WR_CLOSE);
      return t;
   endfunction

endpackage

// File: rtl/sram_step_timer.sv
`timescale 1ns/1ps
module sram_step_timer #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
      (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R8

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int N_RD        = 3,
   parameter int N_TA        = 1,
   parameter int N_WD        = 2,
   parameter int REG_STROBES = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              accept,
   output logic              capture,
   output logic [ADDR_W-1:0] addr_q,
   output strobe_t           stb
);

   localparam int TMAX = imax(imax(N_RD, N_TA), N_WD);
   localparam int CW   = $clog2(TMAX + 1);

   seq_state_e    state_q, state_d;
   logic          t_load, t_done;
   logic [CW-1:0] t_val;

   sram_step_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_done)
   );

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (req) begin
               if (req_wr) begin
                  state_d = ST_WR_OPEN;
               end else begin
                  state_d = ST_RD;
                  t_load  = 1'b1;
                  t_val   = CW'(N_RD - 1);
               end
            end
         end
         ST_RD: begin
            if (t_done) begin
               state_d = ST_TURN;
               t_load  = 1'b1;
               t_val   = CW'(N_TA - 1);
            end
         end
         ST_TURN: begin
            if (t_done) state_d = ST_IDLE;
         end
         ST_WR_OPEN: begin
            state_d = ST_WR_DATA;
            t_load  = 1'b1;
            t_val   = CW'(N_WD - 1);
         end
         ST_WR_DATA: begin
            if (t_done) state_d = ST_WR_CLOSE;
         end
         ST_WR_CLOSE: state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   assign accept  = (state_q == ST_IDLE) && req;
   assign capture = (state_q == ST_RD) && t_done;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) addr_q <= req_addr;
      end
   end

   generate
      if (REG_STROBES != 0) begin : g_reg_strobes
         strobe_t stb_q;
         always_ff @(posedge clk) begin
            if (rst) stb_q <= decode_strobes(ST_IDLE);
            else     stb_q <= decode_strobes(state_d);
         end
         assign stb = stb_q;
      end else begin : g_comb_strobes
         assign stb = decode_strobes(state_q);
      end
   endgenerate

   AST_ADDR_HELD_IN_SELECT: assert property (@(posedge clk) disable iff (rst)
      (stb.cs && $past(stb.cs)) |-> $stable(addr_q)); // R3

   AST_BUSY_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
      (!stb.ready && $past(!stb.ready)) |-> $stable(addr_q)); // R2

endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic [DATA_W-1:0] wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid
);

   always_ff @(posedge clk) begin
      if (rst) begin
         dq_out   <= '0;
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (accept)  dq_out <= wdata;
         if (capture) rdata  <= dq_in;
         rd_valid <= capture;
      end
   end

   AST_RDV_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      rd_valid |=> !rd_valid); // R4

   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
      !rd_valid |-> $stable(rdata)); // R4

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 20,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 20,
   parameter int SPEED_GRADE   = 55,
   parameter int REG_STROBES   = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int C_RC  = ns_to_cyc(grade_ns(SPEED_GRADE, TP_RC),  CLK_PERIOD_NS);
   localparam int C_AA  = ns_to_cyc(grade_ns(SPEED_GRADE, TP_AA),  CLK_PERIOD_NS);
   localparam int C_WC  = ns_to_cyc(grade_ns(SPEED_GRADE, TP_WC),  CLK_PERIOD_NS);
   localparam int C_AW  = ns_to_cyc(grade_ns(SPEED_GRADE, TP_AW),  CLK_PERIOD_NS);
   localparam int C_PWE = ns_to_cyc(grade_ns(SPEED_GRADE, TP_PWE), CLK_PERIOD_NS);
   localparam int C_SD  = ns_to_cyc(grade_ns(SPEED_GRADE, TP_SD),  CLK_PERIOD_NS);
   localparam int C_HZ  = ns_to_cyc(grade_ns(SPEED_GRADE, TP_HZ),  CLK_PERIOD_NS);

   localparam int N_RD = imax(C_RC, C_AA);
   localparam int N_TA = C_HZ;
   localparam int N_WD = imax(imax(C_SD, C_PWE - 1), imax(C_AW - 1, C_WC - 2));

   generate
      if (!(SPEED_GRADE == 55 || SPEED_GRADE == 70)) begin : g_bad_grade
         initial $fatal(1, "SPEED_GRADE must be 55 or 70");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         initial $fatal(1, "CLK_PERIOD_NS must be positive");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         initial $fatal(1, "ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic    accept, capture;
   strobe_t stb;

   sram_ctrl_fsm #(
      .ADDR_W      (ADDR_W),
      .N_RD        (N_RD),
      .N_TA        (N_TA),
      .N_WD        (N_WD),
      .REG_STROBES (REG_STROBES)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .req      (req),
      .req_wr   (req_wr),
      .req_addr (req_addr),
      .accept   (accept),
      .capture  (capture),
      .addr_q   (mem_addr),
      .stb      (stb)
   );

   sram_dq_path #(.DATA_W(DATA_W)) u_dq (
      .clk      (clk),
      .rst      (rst),
      .accept   (accept),
      .wdata    (req_wdata),
      .capture  (capture),
      .dq_in    (mem_dq_in),
      .dq_out   (mem_dq_out),
      .rdata    (rdata),
      .rd_valid (rd_valid)
   );

   assign ready     = stb.ready;
   assign mem_cs1_n = ~stb.cs;
   assign mem_cs2   = stb.cs;
   assign mem_oe_n  = ~stb.oe;
   assign mem_we_n  = ~stb.we;
   assign mem_dq_oe = stb.drv;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      ready |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid)); // R1

   AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> mem_oe_n); // R5

   AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n))); // R6

   AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> mem_dq_oe); // R6

   AST_NO_DRIVE_NEAR_READ: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n))); // R7

   AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> (mem_oe_n && $past(!mem_oe_n))); // R4

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

   localparam int AW     = 8;
   localparam int DW     = 8;
   localparam int PER    = 20;
   localparam real HALF  = 10.0;
   localparam real T_AA  = 55.0;
   localparam real T_DOE = 25.0;
   localparam real T_AW  = 45.0;
   localparam real T_PWE = 40.0;
   localparam real T_SD  = 25.0;
   localparam real T_HZ  = 20.0;
   localparam real T_WC  = 55.0;

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int RD_CYC = mx(cdiv(55), cdiv(55));
   localparam int WE_CYC = 1 + mx(mx(cdiv(25), cdiv(40) - 1), mx(cdiv(45) - 1, cdiv(55) - 2));

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic          req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ready, rd_valid;
   logic [DW-1:0] rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in = 8'hC3;

   always #(PER / 2) clk = ~clk;

   sram_async_ctrl #(
      .ADDR_W        (AW),
      .DATA_W        (DW),
      .CLK_PERIOD_NS (PER),
      .SPEED_GRADE   (55),
      .REG_STROBES   (1)
   ) dut (
      .clk        (clk),
      .rst        (rst),
      .req        (req),
      .req_wr     (req_wr),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .ready      (ready),
      .rdata      (rdata),
      .rd_valid   (rd_valid),
      .mem_addr   (mem_addr),
      .mem_cs1_n  (mem_cs1_n),
      .mem_cs2    (mem_cs2),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe),
      .mem_dq_in  (mem_dq_in)
   );

   int checks = 0;
   int failures = 0;
   bit done_flag = 1'b0;

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", rq, what, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // ---------------- timed memory model ----------------
   logic [DW-1:0] model_mem [256];
   logic [DW-1:0] exp_mem   [256];
   logic sel, rd_en, wr_act;
   assign sel    = !mem_cs1_n && mem_cs2;
   assign rd_en  = sel && mem_we_n && !mem_oe_n;
   assign wr_act = sel && !mem_we_n;

   realtime t_addr = -1000.0, t_rd_on = -1000.0, t_rd_off = -1000.0;
   realtime t_we_fall = -1000.0, t_drv_rise = -1000.0, t_wr_start = -1000.0;

   always @(mem_addr)         t_addr    = $realtime;
   always @(posedge rd_en)    t_rd_on   = $realtime;
   always @(negedge rd_en)    t_rd_off  = $realtime;
   always @(negedge mem_we_n) t_we_fall = $realtime;

   always @(negedge clk) begin
      if (rd_en && ($realtime + HALF - t_addr >= T_AA) && ($realtime + HALF - t_rd_on >= T_DOE))
         mem_dq_in <= model_mem[mem_addr];
      else
         mem_dq_in <= 8'hC3;
   end

   always @(posedge mem_dq_oe) begin
      t_drv_rise = $realtime;
      chk($realtime - t_rd_off >= T_HZ, "R7", "release gap ns", int'($realtime - t_rd_off), int'(T_HZ));
      chk(mem_oe_n == 1'b1, "R7", "oe_n at drive on", int'(mem_oe_n), 1);
   end

   always @(posedge wr_act) begin
      chk($realtime - t_wr_start >= T_WC, "R5", "write start spacing ns", int'($realtime - t_wr_start), int'(T_WC));
      chk(mem_oe_n == 1'b1, "R5", "oe_n at write start", int'(mem_oe_n), 1);
      t_wr_start = $realtime;
   end

   always @(negedge wr_act) begin
      chk($realtime - t_we_fall >= T_PWE, "R5", "we pulse ns", int'($realtime - t_we_fall), int'(T_PWE));
      chk($realtime - t_addr >= T_AW, "R5", "addr to write end ns", int'($realtime - t_addr), int'(T_AW));
      chk(mem_dq_oe && ($realtime - t_drv_rise >= T_SD), "R6", "data setup ns", int'($realtime - t_drv_rise), int'(T_SD));
      if (mem_dq_oe) model_mem[mem_addr] = mem_dq_out;
      else           model_mem[mem_addr] = 8'hEE;
   end

   // ---------------- watchdog ----------------
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, 150000);
         finish_up();
      end
   end

   // ---------------- host tasks ----------------
   task automatic check_idle(input string rq);
      chk(ready == 1'b1, rq, "ready", int'(ready), 1);
      chk(mem_cs1_n == 1'b1 && mem_cs2 == 1'b0, rq, "deselected cs1_n/cs2",
          int'({mem_cs1_n, mem_cs2}), 2);
      chk(mem_oe_n == 1'b1 && mem_we_n == 1'b1, rq, "oe_n/we_n", int'({mem_oe_n, mem_we_n}), 3);
      chk(mem_dq_oe == 1'b0 && rd_valid == 1'b0, rq, "dq_oe/rd_valid", int'({mem_dq_oe, rd_valid}), 0);
   endtask

   task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int oe_c, output int we_c, output int rv_c, output int lag,
                         output logic [DW-1:0] rv_d);
      int cyc;
      int last_oe;
      req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
      while (!ready) @(negedge clk);
      @(negedge clk);
      req = 1'b0;
      oe_c = 0; we_c = 0; rv_c = 0; lag = -1; last_oe = -100; cyc = 0; rv_d = '0;
      while (!ready) begin
         if (!mem_oe_n) begin oe_c++; last_oe = cyc; end
         if (!mem_we_n) we_c++;
         if (rd_valid) begin rv_c++; rv_d = rdata; lag = cyc - last_oe; end
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit full);
      int oe_c, we_c, rv_c, lag;
      logic [DW-1:0] rv_d;
      run_op(1'b1, a, d, oe_c, we_c, rv_c, lag, rv_d);
      exp_mem[a] = d;
      chk(we_c == WE_CYC, "R8", "we low cycles", we_c, WE_CYC);
      chk(oe_c == 0, "R5", "oe low cycles in write", oe_c, 0);
      if (full) check_idle("R1");
   endtask

   task automatic do_read(input logic [AW-1:0] a, input bit full);
      int oe_c, we_c, rv_c, lag;
      logic [DW-1:0] rv_d;
      run_op(1'b0, a, '0, oe_c, we_c, rv_c, lag, rv_d);
      chk(rv_d == exp_mem[a], "R9", "read data", int'(rv_d), int'(exp_mem[a]));
      chk(oe_c == RD_CYC, "R3", "oe low cycles", oe_c, RD_CYC);
      chk(rv_c == 1 && lag == 1, "R4", "rd_valid count/lag", rv_c * 10 + lag, 11);
      chk(rdata == rv_d, "R4", "rdata held", int'(rdata), int'(rv_d));
      chk(we_c == 0, "R3", "we low cycles in read", we_c, 0);
      if (full) check_idle("R1");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         model_mem[i] = DW'(i ^ 8'h5A);
         exp_mem[i]   = DW'(i ^ 8'h5A);
      end
      repeat (3) @(negedge clk);
      check_idle("R1");
      rst = 1'b0;
      @(negedge clk);
      check_idle("R1");

      // sweep: write every address, then read every address
      for (int a = 0; a < 256; a++) do_write(AW'(a), DW'((a * 37 + 11) & 8'hFF), a < 4);
      for (int a = 0; a < 256; a++) do_read(AW'(a), a < 4);

      // interleaved write/read, descending, inverted pattern: read->write turnaround each step
      for (int a = 255; a >= 0; a--) begin
         do_write(AW'(a), DW'(~((a * 37 + 11) & 8'hFF)), 1'b0);
         do_read(AW'(a), 1'b0);
         do_read(AW'((a + 1) & 8'hFF), 1'b0);
      end

      // R2: request raised while busy is ignored
      begin
         logic [DW-1:0] before6;
         before6 = exp_mem[6];
         req = 1'b1; req_wr = 1'b1; req_addr = 8'd5; req_wdata = 8'h11;
         while (!ready) @(negedge clk);
         @(negedge clk);
         req_addr = 8'd6; req_wdata = 8'h22;
         chk(ready == 1'b0, "R2", "ready while busy", int'(ready), 0);
         @(negedge clk);
         req = 1'b0;
         chk(mem_addr == 8'd5, "R2", "mem_addr kept while busy", int'(mem_addr), 5);
         while (!ready) @(negedge clk);
         exp_mem[5] = 8'h11;
         do_read(8'd6, 1'b1);
         chk(exp_mem[6] == before6, "R2", "ignored write left address 6", int'(exp_mem[6]), int'(before6));
         do_read(8'd5, 1'b1);
      end

      // R7/R2: write request pending while a read returns its data
      begin
         int saw_rv;
         saw_rv = 0;
         req = 1'b1; req_wr = 1'b0; req_addr = 8'd40;
         while (!ready) @(negedge clk);
         @(negedge clk);
         req_wr = 1'b1; req_addr = 8'd41; req_wdata = 8'h9C;
         while (!ready) begin
            if (rd_valid) begin
               saw_rv++;
               chk(rdata == exp_mem[40], "R4", "read data under pending write", int'(rdata), int'(exp_mem[40]));
               chk(ready == 1'b0 && mem_dq_oe == 1'b0, "R7", "no drive in rd_valid cycle",
                   int'({ready, mem_dq_oe}), 0);
            end
            @(negedge clk);
         end
         chk(saw_rv == 1, "R4", "rd_valid pulses", saw_rv, 1);
         @(negedge clk);
         req = 1'b0;
         while (!ready) @(negedge clk);
         exp_mem[41] = 8'h9C;
         do_read(8'd41, 1'b1);
         do_read(8'd40, 1'b1);
      end

      // R1: reset in the middle of a read returns to idle
      req = 1'b1; req_wr = 1'b0; req_addr = 8'd3;
      @(negedge clk);
      req = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check_idle("R1");

      finish_up();
   end

endmodule